// File: doc/BRIEF.md
# Event-Register Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt lines and hands them to a small set of CPUs through one register port. Each source carries a mask flag, a software-pending flag and a routing word with one bit per CPU. A source is live when its input line or its software-pending flag is high and its mask flag is clear. Each CPU has an IRQ output that is high while any live source is routed to it.

A CPU services interrupts by reading the event register repeatedly. Each read reports the lowest-numbered live source routed to the CPU named on the request's CPU-id sideband. In the same clock edge, the reported source is masked. The next read therefore reports the next source, and a read that finds nothing returns an all-zero word. Software unmasks a source again through the write-one-to-clear mask bank once it has serviced the source.

The port is a single-cycle request interface. Writes take effect at the clock edge that accepts them. Read data appears one cycle later with a valid strobe. A two-state machine paces the port. In `PORT_IDLE`, a read request moves it to `PORT_RESP` and any other cycle keeps it in `PORT_IDLE`. In `PORT_RESP`, a further read request keeps it in `PORT_RESP` and any other cycle returns it to `PORT_IDLE`. The response strobe is high exactly in `PORT_RESP`.

Top module: `evt_ic`

## Requirements
- R1: After reset every mask flag is set, every software-pending flag is clear, every routing word is 0, both IRQ outputs are low and an event read returns 0.
- R2: A read of address 0x0004 returns the number of sources in bits 15:0 and zero above them.
- R3: Each mask bank holds one word per group of 32 sources. Source n sits at bit n mod 32 of the word at base + 4*(n/32). The set bank is at base 0x4100 and the clear bank at base 0x4180. A 1 in written data sets or clears the flag, and a 0 leaves it unchanged. Reading either bank returns the current mask word, with 1 meaning masked.
- R4: The software-pending set bank (base 0x4000) and clear bank (base 0x4080) use the same banking as the mask banks. A set flag makes a source pending while its line is low, until the flag is cleared. Reading either bank returns the pending-flag word.
- R5: The routing word of source n is at 0x3000 + 4*n. Bit c routes the source to CPU c, and only the low NUM_CPU bits are stored. Reads return the stored bits with zero above them.
- R6: An event read returns type 1 in bits 31:16 and the source number in bits 15:0. The source is the lowest-numbered live source whose routing bit for the requesting CPU is set. When there is no such source, the read returns 0.
- R7: A read that reports a source sets that source's mask flag at the same clock edge. A following read therefore reports the next source. The source stays masked until the mask-clear bank is written.
- R8: IRQ output c is high exactly when some live source has routing bit c set.
- R9: Sources are level-sensitive. When a line falls and its software-pending flag is clear, the source stops being pending with nothing latched.
- R10: A read request produces a response strobe and data in the following cycle. A cycle without a read request produces no strobe in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | CPU_W | Identity of the requesting CPU |
| req_addr | input | 16 | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| irq_in | input | NUM_SRC | Level interrupt lines |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | NUM_CPU | Per-CPU interrupt request |

## Verification
The selection of a source and a change on the input lines can fall in the same clock edge. In that case the event read must judge against the line levels sampled at that edge, and only the reported source may be masked. The bench raises a lower-numbered line in the very cycle that an event read is presented while a higher-numbered source is already waiting. It then expects the new lower source to be reported first and masked, and the waiting source to follow on the next read. It also checks the final mask word, so a masking error on either source shows up.

// File: rtl/evt_ic_pkg.sv
package evt_ic_pkg;

    localparam int ADDR_W = 16;

    localparam logic [15:0] ADR_INFO     = 16'h0004;
    localparam logic [15:0] ADR_EVENT    = 16'h2004;
    localparam logic [15:0] ADR_ROUTE    = 16'h3000;
    localparam logic [15:0] ADR_PEND_SET = 16'h4000;
    localparam logic [15:0] ADR_PEND_CLR = 16'h4080;
    localparam logic [15:0] ADR_MASK_SET = 16'h4100;
    localparam logic [15:0] ADR_MASK_CLR = 16'h4180;

    localparam logic [15:0] EVT_TYPE_NONE = 16'd0;
    localparam logic [15:0] EVT_TYPE_HW   = 16'd1;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_INFO,
        RK_EVENT,
        RK_ROUTE,
        RK_PSET,
        RK_PCLR,
        RK_MSET,
        RK_MCLR
    } reg_kind_e;

    typedef enum logic {
        PORT_IDLE,
        PORT_RESP
    } port_state_e;

endpackage

// File: rtl/evt_ic_bank.sv
module evt_ic_bank
    import evt_ic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    parameter int SRC_W   = 6,
    parameter int NWORD   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  reg_kind_e          wr_kind,
    input  logic [4:0]         acc_word,
    input  logic [SRC_W-1:0]   acc_src,
    input  logic [31:0]        wr_data,
    input  logic               ack_fire,
    input  logic [SRC_W-1:0]   ack_idx,
    output logic [NUM_SRC-1:0] mask_vec,
    output logic [NUM_SRC-1:0] pend_vec,
    output logic [NUM_CPU-1:0] route_q [NUM_SRC],
    output logic [31:0]        mask_word,
    output logic [31:0]        pend_word,
    output logic [NUM_CPU-1:0] route_word
);

    // Per-word mask and software-pending storage
    for (genvar w = 0; w < NWORD; w++) begin : g_word
        logic [31:0] m_q;
        logic [31:0] p_q;
        logic        hit_word;

        assign hit_word = (acc_word == 5'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_q <= '1;
                p_q <= '0;
            end else begin
                for (int b = 0; b < 32; b++) begin
                    if (hit_word && wr_kind == RK_MSET && wr_data[b]) begin
                        m_q[b] <= 1'b1;
                    end
                    if (hit_word && wr_kind == RK_MCLR && wr_data[b]) begin
                        m_q[b] <= 1'b0;
                    end
                    if (hit_word && wr_kind == RK_PSET && wr_data[b]) begin
                        p_q[b] <= 1'b1;
                    end
                    if (hit_word && wr_kind == RK_PCLR && wr_data[b]) begin
                        p_q[b] <= 1'b0;
                    end
                    if (ack_fire && ack_idx == SRC_W'(w * 32 + b)) begin
                        m_q[b] <= 1'b1;
                    end
                end
            end
        end

        assign mask_vec[w*32 +: 32] = m_q;
        assign pend_vec[w*32 +: 32] = p_q;
    end

    // Routing words, one per source
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int n = 0; n < NUM_SRC; n++) begin
                route_q[n] <= '0;
            end
        end else if (wr_kind == RK_ROUTE) begin
            route_q[acc_src] <= wr_data[NUM_CPU-1:0];
        end
    end

    // Read-side word selection
    always_comb begin
        mask_word = '0;
        pend_word = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (acc_word == 5'(w)) begin
                mask_word = mask_vec[w*32 +: 32];
                pend_word = pend_vec[w*32 +: 32];
            end
        end
        route_word = route_q[acc_src];
    end

    AST_ACK_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_fire |=> mask_vec[$past(ack_idx)]); // R7

endmodule

// File: rtl/evt_ic_picker.sv
module evt_ic_picker #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    parameter int SRC_W   = 6,
    parameter int CPU_W   = 1
) (
    input  logic [NUM_SRC-1:0] live,
    input  logic [NUM_CPU-1:0] route_q [NUM_SRC],
    input  logic [CPU_W-1:0]   sel_cpu,
    output logic [NUM_CPU-1:0] irq_out,
    output logic               hit,
    output logic [SRC_W-1:0]   hit_idx
);

    logic [NUM_SRC-1:0] routed [NUM_CPU];
    logic [NUM_SRC-1:0] sel_vec;

    // One routed vector and IRQ reduction per CPU
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            assign routed[c][n] = live[n] & route_q[n][c];
        end
        assign irq_out[c] = |routed[c];
    end

    // Requesting CPU's vector and lowest-index search
    always_comb begin
        sel_vec = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (sel_cpu == CPU_W'(c)) begin
                sel_vec = routed[c];
            end
        end
        hit     = |sel_vec;
        hit_idx = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (sel_vec[n]) begin
                hit_idx = SRC_W'(n);
            end
        end
    end

endmodule

// File: rtl/evt_ic_port.sv
module evt_ic_port
    import evt_ic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    parameter int SRC_W   = 6,
    parameter int NWORD   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [15:0]        req_addr,
    input  logic [31:0]        req_wdata,
    input  logic               hit,
    input  logic [SRC_W-1:0]   hit_idx,
    input  logic [31:0]        mask_word,
    input  logic [31:0]        pend_word,
    input  logic [NUM_CPU-1:0] route_word,
    output reg_kind_e          wr_kind,
    output logic [4:0]         acc_word,
    output logic [SRC_W-1:0]   acc_src,
    output logic [31:0]        wr_data,
    output logic               ack_fire,
    output logic [SRC_W-1:0]   ack_idx,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata
);

    port_state_e state_q, state_d;
    reg_kind_e   kind;
    logic [15:0] route_off;
    logic        word_ok;
    logic        rd_req;
    logic [31:0] rd_next;
    logic [31:0] rdata_q;

    // Address decode
    always_comb begin
        route_off = req_addr - ADR_ROUTE;
        acc_word  = req_addr[6:2];
        acc_src   = SRC_W'(route_off >> 2);
        word_ok   = (int'(req_addr[6:2]) < NWORD);
        kind      = RK_NONE;
        if (req_addr[1:0] == 2'b00) begin
            if (req_addr == ADR_INFO) begin
                kind = RK_INFO;
            end else if (req_addr == ADR_EVENT) begin
                kind = RK_EVENT;
            end else if (req_addr >= ADR_ROUTE &&
                         req_addr < ADR_ROUTE + 16'(4 * NUM_SRC)) begin
                kind = RK_ROUTE;
            end else if (word_ok && req_addr[15:7] == ADR_PEND_SET[15:7]) begin
                kind = RK_PSET;
            end else if (word_ok && req_addr[15:7] == ADR_PEND_CLR[15:7]) begin
                kind = RK_PCLR;
            end else if (word_ok && req_addr[15:7] == ADR_MASK_SET[15:7]) begin
                kind = RK_MSET;
            end else if (word_ok && req_addr[15:7] == ADR_MASK_CLR[15:7]) begin
                kind = RK_MCLR;
            end
        end
    end

    assign rd_req   = req_valid && !req_write;
    assign wr_kind  = (req_valid && req_write) ? kind : RK_NONE;
    assign wr_data  = req_wdata;
    assign ack_fire = rd_req && (kind == RK_EVENT) && hit;
    assign ack_idx  = hit_idx;

    // Read data selection
    always_comb begin
        unique case (kind)
            RK_NONE:  rd_next = '0;
            RK_INFO:  rd_next = 32'(NUM_SRC);
            RK_EVENT: rd_next = hit ? {EVT_TYPE_HW, 16'(hit_idx)}
                                    : {EVT_TYPE_NONE, 16'd0};
            RK_ROUTE: rd_next = 32'(route_word);
            RK_PSET:  rd_next = pend_word;
            RK_PCLR:  rd_next = pend_word;
            RK_MSET:  rd_next = mask_word;
            RK_MCLR:  rd_next = mask_word;
            default:  rd_next = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PORT_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) begin
                rdata_q <= rd_next;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_IDLE: state_d = rd_req ? PORT_RESP : PORT_IDLE;
            PORT_RESP: state_d = rd_req ? PORT_RESP : PORT_IDLE;
            default:   state_d = PORT_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rsp_valid = (state_q == PORT_RESP);
        rsp_rdata = rsp_valid ? rdata_q : '0;
    end

    AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid); // R10
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid); // R10

endmodule

// File: rtl/evt_ic.sv
module evt_ic
    import evt_ic_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 2,
    parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [CPU_W-1:0]   req_cpu,
    input  logic [15:0]        req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata,
    output logic [NUM_CPU-1:0] irq_out
);

    localparam int SRC_W = $clog2(NUM_SRC);
    localparam int NWORD = NUM_SRC / 32;

    reg_kind_e          wr_kind;
    logic [4:0]         acc_word;
    logic [SRC_W-1:0]   acc_src;
    logic [31:0]        wr_data;
    logic               ack_fire;
    logic [SRC_W-1:0]   ack_idx;
    logic [NUM_SRC-1:0] mask_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_CPU-1:0] route_q [NUM_SRC];
    logic [31:0]        mask_word;
    logic [31:0]        pend_word;
    logic [NUM_CPU-1:0] route_word;
    logic [NUM_SRC-1:0] live;
    logic               hit;
    logic [SRC_W-1:0]   hit_idx;

    assign live = (irq_in | pend_vec) & ~mask_vec;

    evt_ic_bank #(
        .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .SRC_W(SRC_W), .NWORD(NWORD)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_kind(wr_kind), .acc_word(acc_word),
        .acc_src(acc_src), .wr_data(wr_data), .ack_fire(ack_fire),
        .ack_idx(ack_idx), .mask_vec(mask_vec), .pend_vec(pend_vec),
        .route_q(route_q), .mask_word(mask_word), .pend_word(pend_word),
        .route_word(route_word)
    );

    evt_ic_picker #(
        .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .SRC_W(SRC_W), .CPU_W(CPU_W)
    ) u_pick (
        .live(live), .route_q(route_q), .sel_cpu(req_cpu),
        .irq_out(irq_out), .hit(hit), .hit_idx(hit_idx)
    );

    evt_ic_port #(
        .NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .SRC_W(SRC_W), .NWORD(NWORD)
    ) u_port (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .hit(hit), .hit_idx(hit_idx),
        .mask_word(mask_word), .pend_word(pend_word), .route_word(route_word),
        .wr_kind(wr_kind), .acc_word(acc_word), .acc_src(acc_src),
        .wr_data(wr_data), .ack_fire(ack_fire), .ack_idx(ack_idx),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    AST_EVT_HIT_TYPED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADR_EVENT && irq_out[req_cpu])
        |=> rsp_rdata[31:16] == EVT_TYPE_HW); // R8
    AST_EVT_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == ADR_EVENT && !irq_out[req_cpu])
        |=> rsp_rdata == 32'd0); // R6

endmodule

// File: tb/evt_ic_bench.sv
module evt_ic_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_write;
    logic [0:0]  req_cpu;
    logic [15:0] req_addr;
    logic [31:0] req_wdata;
    logic [63:0] irq_in;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [1:0]  irq_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    evt_ic u_evt_ic (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_cpu(req_cpu), .req_addr(req_addr), .req_wdata(req_wdata),
        .irq_in(irq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R10 no strobe after write", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic bus_read(input int cpu, input logic [15:0] a,
                            input logic [63:0] raise, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_cpu = cpu[0:0]; req_addr = a;
        irq_in = irq_in | raise;
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 strobe after read", {31'd0, rsp_valid}, 32'd1);
        d = rsp_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq_out after reset", {30'd0, irq_out}, 32'd0);
        bus_read(0, 16'h2004, 64'd0, d);  check("R1 event empty", d, 32'd0);
        bus_read(0, 16'h4100, 64'd0, d);  check("R1 mask word0", d, 32'hFFFF_FFFF);
        bus_read(0, 16'h4184, 64'd0, d);  check("R1 mask word1", d, 32'hFFFF_FFFF);
        bus_read(0, 16'h4000, 64'd0, d);  check("R1 pend word0", d, 32'd0);
        bus_read(1, 16'h3014, 64'd0, d);  check("R1 route src5", d, 32'd0);
    endtask

    task automatic t_info();
        logic [31:0] d;
        bus_read(0, 16'h0004, 64'd0, d);  check("R2 source count", d, 32'd64);
    endtask

    task automatic t_route();
        logic [31:0] d;
        bus_write(16'h300C, 32'h1);
        bus_read(0, 16'h300C, 64'd0, d);  check("R5 route src3", d, 32'h1);
        bus_write(16'h300C, 32'hFFFF_FFFF);
        bus_read(0, 16'h300C, 64'd0, d);  check("R5 route width", d, 32'h3);
        bus_write(16'h300C, 32'h1);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        irq_in[3] = 1'b1;
        @(negedge clk);
        check("R3 masked line quiet", {30'd0, irq_out}, 32'd0);
        bus_write(16'h4180, 32'h8);
        check("R8 irq to cpu0 only", {30'd0, irq_out}, 32'h1);
        bus_read(0, 16'h4100, 64'd0, d);  check("R3 mask after clear", d, 32'hFFFF_FFF7);
        bus_write(16'h4100, 32'h0);
        bus_write(16'h4180, 32'h0);
        bus_read(1, 16'h4180, 64'd0, d);  check("R3 zero writes ignored", d, 32'hFFFF_FFF7);
        check("R3 irq unchanged", {30'd0, irq_out}, 32'h1);
    endtask

    task automatic t_ack();
        logic [31:0] d;
        bus_read(0, 16'h2004, 64'd0, d);  check("R6 event src3", d, 32'h0001_0003);
        check("R7 irq drops after ack", {30'd0, irq_out}, 32'd0);
        bus_read(0, 16'h4100, 64'd0, d);  check("R7 auto mask", d, 32'hFFFF_FFFF);
        bus_read(0, 16'h2004, 64'd0, d);  check("R7 next read empty", d, 32'd0);
        irq_in[3] = 1'b0;
    endtask

    task automatic t_order();
        logic [31:0] d;
        bus_write(16'h3014, 32'h1);
        bus_write(16'h30A0, 32'h3);
        irq_in[5] = 1'b1;
        bus_write(16'h4180, 32'h20);
        bus_write(16'h4184, 32'h100);
        bus_write(16'h4004, 32'h100);
        check("R8 both cpus", {30'd0, irq_out}, 32'h3);
        bus_read(0, 16'h4004, 64'd0, d);  check("R4 pend word1", d, 32'h100);
        bus_read(1, 16'h2004, 64'd0, d);  check("R6 cpu1 sees src40", d, 32'h0001_0028);
        bus_read(0, 16'h2004, 64'd0, d);  check("R6 cpu0 sees src5", d, 32'h0001_0005);
        bus_read(0, 16'h2004, 64'd0, d);  check("R7 all acked", d, 32'd0);
        bus_write(16'h4184, 32'h100);
        bus_read(0, 16'h2004, 64'd0, d);  check("R4 soft pending persists", d, 32'h0001_0028);
        bus_write(16'h4084, 32'h100);
        bus_read(0, 16'h4084, 64'd0, d);  check("R4 pend cleared", d, 32'd0);
        bus_write(16'h4184, 32'h100);
        check("R4 nothing pending", {30'd0, irq_out}, 32'd0);
        bus_read(0, 16'h2004, 64'd0, d);  check("R4 event empty", d, 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        bus_write(16'h4180, 32'h20);
        check("R9 line high pends", {30'd0, irq_out}, 32'h1);
        irq_in[5] = 1'b0;
        @(negedge clk);
        check("R9 line low clears", {30'd0, irq_out}, 32'd0);
        bus_read(0, 16'h2004, 64'd0, d);  check("R9 no latched event", d, 32'd0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        bus_write(16'h3008, 32'h1);
        bus_write(16'h3024, 32'h1);
        irq_in[9] = 1'b1;
        bus_write(16'h4180, 32'h204);
        bus_read(0, 16'h2004, 64'h4, d);  check("R6 new low source wins", d, 32'h0001_0002);
        bus_read(0, 16'h2004, 64'd0, d);  check("R7 waiting source next", d, 32'h0001_0009);
        bus_read(0, 16'h2004, 64'd0, d);  check("R7 both acked", d, 32'd0);
        bus_read(0, 16'h4100, 64'd0, d);  check("R7 mask word0", d, 32'hFFFF_FFDF);
        irq_in = '0;
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_cpu = '0;
        req_addr = '0; req_wdata = '0; irq_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_info();
        t_route();
        t_mask();
        t_ack();
        t_order();
        t_level();
        t_same_cycle();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule